// File: doc/BRIEF.md
# Periodic Schedule Walker

This block runs the per-frame part of a host-side serial-bus scheduler. On every frame tick it moves the frame number on by one and reports the interrupt requests gathered during the previous frame. It then reads one entry of a frame list held in memory and follows the linked schedule from that entry. The schedule is made of queue heads and transfer descriptors. The walker gives each descriptor it reaches to an outside execution unit, then acts on the result code that unit returns. It writes back descriptor control words that changed and moves the element pointers of queue heads forward.

Memory is reached through a single word port with a request/acknowledge handshake, and only one access is in flight at a time. Descriptor execution uses a second request/done handshake. The walk for a frame ends in one of three ways: the walker meets a terminate pointer, it receives an abort result, or it reaches a fixed budget of visits.

Top module: `frame_walker`

## Requirements
- R1: After reset the frame number is 0, `halted_o` is 1, `busy_o`, `int_post_o`, `mem_req_o` and `exec_req_o` are 0.
- R2: A tick that arrives while idle with `run_i` set adds one to `frame_num_o` modulo 2048, clears `halted_o` and starts a walk.
- R3: A tick that arrives while idle with `run_i` clear sets `halted_o`, leaves the frame number unchanged and makes no memory access.
- R4: The first access of a walk is a read at `{list_page_i, frame_num_o[9:0], 2'b00}`.
- R5: Pointer bit 0 means terminate and bit 1 selects a queue head; the address is the pointer with bits 3:0 cleared. A queue head at address A holds its horizontal link at A and its element link at A+4. If the element link terminates, the walker follows the horizontal link. If the element link selects a queue head, the walker descends into it and drops the outer horizontal link.
- R6: Result codes are 0 advance, 1 retry, 2 abort, and 3 is treated as retry. A descriptor reached by a horizontal link is executed with any result other than abort, and the walk goes on with that descriptor's own link at D+0.
- R7: The control word at D+4 is passed to the execution unit. The word returned is written to D+4 only when it differs from the word that was read.
- R8: When a descriptor inside a queue head gives an advance result, the descriptor's link becomes the element link and is written to A+4. If bit 2 of that link is set, the same queue head is processed again; otherwise the walker takes the horizontal link. Any other non-abort result leaves the element link as it was and takes the horizontal link.
- R9: An abort result ends the walk for the frame, after the control-word write-back if one is due.
- R10: At most `MAX_VISITS` queue-head visits plus descriptor executions take place in one frame.
- R11: The interrupt bits returned with each execution are ORed together during a frame. At the next accepted tick they appear on `int_bits_o` with a one-cycle `int_post_o` pulse, and only if they are nonzero.
- R12: `mem_req_o` stays high, with a stable address and direction, until `mem_ack_i`. `exec_req_o` likewise stays high, with a stable address, until `exec_done_i`.
- R13: A tick that arrives while a walk is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_tick_i | input | 1 | Frame start pulse |
| run_i | input | 1 | Run enable |
| list_page_i | input | AW-12 | Frame list base, upper address bits |
| frame_num_o | output | 11 | Frame number |
| halted_o | output | 1 | Halted status |
| int_post_o | output | 1 | Interrupt post pulse |
| int_bits_o | output | 2 | Interrupt bits collected in the previous frame |
| busy_o | output | 1 | Walk in progress |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write (1) or read (0) |
| mem_addr_o | output | AW | Memory word address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_ack_i | input | 1 | Memory access complete, read data valid |
| mem_rdata_i | input | 32 | Memory read data |
| exec_req_o | output | 1 | Descriptor execution request |
| exec_addr_o | output | AW | Descriptor address |
| exec_ctrl_o | output | 32 | Descriptor control word as read |
| exec_done_i | input | 1 | Execution complete |
| exec_result_i | input | 2 | Result code |
| exec_ctrl_i | input | 32 | Updated control word |
| exec_irq_i | input | 2 | Interrupt bits raised by the descriptor |

## Verification
The frame-list lookup is swept over every frame number through a full wrap, with a base whose low bits are non-zero, so that a wrong index slice, a wrong shift or a missing wrap would each appear. Hand-built schedules then separate the traversal modes: a horizontal descriptor chain with a retry result, a queue that advances depth-first, two queues walked breadth-first, a nested queue whose outer horizontal link must be dropped, and an abort placed ahead of an executable descriptor. A queue head linked to itself exposes the visit budget through the exact read count, and a tick placed inside that long walk shows whether a busy tick is ignored. Interrupt posting is checked on the frame after a descriptor raises bits and again on a frame with none.

// File: rtl/fw_pkg.sv
package fw_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_ENTRY, ST_LDEC, ST_QH0, ST_QH1, ST_QDEC,
    ST_TD0, ST_TD1, ST_EXEC, ST_TDWB, ST_POST, ST_QHWB
  } walk_st_e;

  localparam logic [1:0] RES_ADVANCE = 2'd0;
  localparam logic [1:0] RES_ABORT   = 2'd2;

  localparam int PTR_TERM  = 0;
  localparam int PTR_QUEUE = 1;
  localparam int PTR_DEPTH = 2;
endpackage

// File: rtl/fw_frame_ctr.sv
module fw_frame_ctr #(
  parameter int FN_W  = 11,
  parameter int IRQ_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             run_i,
  input  logic             busy_i,
  input  logic             irq_vld_i,
  input  logic [IRQ_W-1:0] irq_i,
  output logic [FN_W-1:0]  frame_o,
  output logic             halted_o,
  output logic             post_o,
  output logic [IRQ_W-1:0] post_bits_o,
  output logic             start_o
);
  logic             idle;
  logic             accept;
  logic [FN_W-1:0]  frame_n;
  logic             halted_n, post_n, start_n;
  logic [IRQ_W-1:0] bits_n, acc_q, acc_n;

  assign idle   = ~busy_i & ~start_o;
  assign accept = tick_i & run_i & idle;

  always_comb begin
    frame_n  = frame_o;
    halted_n = halted_o;
    post_n   = 1'b0;
    bits_n   = post_bits_o;
    acc_n    = acc_q;
    start_n  = accept;
    if (irq_vld_i) acc_n = acc_q | irq_i;
    if (accept) begin
      frame_n  = frame_o + 1'b1;
      halted_n = 1'b0;
      post_n   = |acc_q;
      bits_n   = acc_q;
      acc_n    = '0;
    end else if (tick_i && !run_i && idle) begin
      halted_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_o     <= '0;
      halted_o    <= 1'b1;
      post_o      <= 1'b0;
      post_bits_o <= '0;
      acc_q       <= '0;
      start_o     <= 1'b0;
    end else begin
      frame_o     <= frame_n;
      halted_o    <= halted_n;
      post_o      <= post_n;
      post_bits_o <= bits_n;
      acc_q       <= acc_n;
      start_o     <= start_n;
    end
  end

  // R3
  halt_on_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !run_i && !busy_i && !start_o) |=> halted_o);
  // R11
  post_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    post_o |-> (post_bits_o != '0));
  // R13
  busy_tick_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |=> $stable(frame_o));
endmodule

// File: rtl/fw_visit_budget.sv
module fw_visit_budget #(
  parameter int MAX_VISITS = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic inc_i,
  output logic exhausted_o
);
  localparam int VC_W = $clog2(MAX_VISITS + 1);
  localparam logic [VC_W-1:0] LIMIT = VC_W'(MAX_VISITS);

  logic [VC_W-1:0] cnt_q, cnt_n;

  always_comb begin
    cnt_n = cnt_q;
    if (clr_i)      cnt_n = '0;
    else if (inc_i) cnt_n = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  assign exhausted_o = (cnt_q >= LIMIT);

  // R10
  budget_no_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inc_i |-> !exhausted_o);
endmodule

// File: rtl/frame_walker.sv
module frame_walker
  import fw_pkg::*;
#(
  parameter int AW         = 32,
  parameter int FN_W       = 11,
  parameter int LIST_IDX_W = 10,
  parameter int IRQ_W      = 2,
  parameter int MAX_VISITS = 100
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      frame_tick_i,
  input  logic                      run_i,
  input  logic [AW-LIST_IDX_W-3:0]  list_page_i,
  output logic [FN_W-1:0]           frame_num_o,
  output logic                      halted_o,
  output logic                      int_post_o,
  output logic [IRQ_W-1:0]          int_bits_o,
  output logic                      busy_o,
  output logic                      mem_req_o,
  output logic                      mem_we_o,
  output logic [AW-1:0]             mem_addr_o,
  output logic [31:0]               mem_wdata_o,
  input  logic                      mem_ack_i,
  input  logic [31:0]               mem_rdata_i,
  output logic                      exec_req_o,
  output logic [AW-1:0]             exec_addr_o,
  output logic [31:0]               exec_ctrl_o,
  input  logic                      exec_done_i,
  input  logic [1:0]                exec_result_i,
  input  logic [31:0]               exec_ctrl_i,
  input  logic [IRQ_W-1:0]          exec_irq_i
);
  localparam logic [AW-1:0] PTR_MASK = {{(AW-4){1'b1}}, 4'b0000};
  localparam logic [AW-1:0] WORD1    = AW'(4);

  walk_st_e    st_q, st_n;
  logic [31:0] link_q, link_n, horiz_q, horiz_n, elem_q, elem_n;
  logic [31:0] tdlink_q, tdlink_n, ctrl_q, ctrl_n, ctrl_new_q, ctrl_new_n;
  logic [AW-1:0] qh_q, qh_n, td_q, td_n;
  logic [1:0]  res_q, res_n;
  logic        inq_q, inq_n;
  logic        start, exhausted, visit_inc;

  fw_frame_ctr #(.FN_W(FN_W), .IRQ_W(IRQ_W)) u_frame (
    .clk, .rst_n, .tick_i(frame_tick_i), .run_i, .busy_i(busy_o),
    .irq_vld_i(st_q == ST_EXEC && exec_done_i), .irq_i(exec_irq_i),
    .frame_o(frame_num_o), .halted_o, .post_o(int_post_o),
    .post_bits_o(int_bits_o), .start_o(start));

  fw_visit_budget #(.MAX_VISITS(MAX_VISITS)) u_budget (
    .clk, .rst_n, .clr_i(start), .inc_i(visit_inc), .exhausted_o(exhausted));

  always_comb begin
    st_n = st_q; link_n = link_q; horiz_n = horiz_q; elem_n = elem_q;
    tdlink_n = tdlink_q; ctrl_n = ctrl_q; ctrl_new_n = ctrl_new_q;
    qh_n = qh_q; td_n = td_q; res_n = res_q; inq_n = inq_q;
    visit_inc = 1'b0;
    unique case (st_q)
      ST_IDLE:  if (start) st_n = ST_ENTRY;
      ST_ENTRY: if (mem_ack_i) begin link_n = mem_rdata_i; st_n = ST_LDEC; end
      ST_LDEC: begin
        if (link_q[PTR_TERM] || exhausted) st_n = ST_IDLE;
        else if (link_q[PTR_QUEUE]) begin
          qh_n = AW'(link_q) & PTR_MASK; visit_inc = 1'b1; st_n = ST_QH0;
        end else begin
          td_n = AW'(link_q) & PTR_MASK; inq_n = 1'b0; visit_inc = 1'b1; st_n = ST_TD0;
        end
      end
      ST_QH0: if (mem_ack_i) begin horiz_n = mem_rdata_i; st_n = ST_QH1; end
      ST_QH1: if (mem_ack_i) begin elem_n = mem_rdata_i; st_n = ST_QDEC; end
      ST_QDEC: begin
        if (elem_q[PTR_TERM])       begin link_n = horiz_q; st_n = ST_LDEC; end
        else if (elem_q[PTR_QUEUE]) begin link_n = elem_q;  st_n = ST_LDEC; end
        else if (exhausted)         st_n = ST_IDLE;
        else begin
          td_n = AW'(elem_q) & PTR_MASK; inq_n = 1'b1; visit_inc = 1'b1; st_n = ST_TD0;
        end
      end
      ST_TD0: if (mem_ack_i) begin tdlink_n = mem_rdata_i; st_n = ST_TD1; end
      ST_TD1: if (mem_ack_i) begin ctrl_n = mem_rdata_i; st_n = ST_EXEC; end
      ST_EXEC: if (exec_done_i) begin
        ctrl_new_n = exec_ctrl_i;
        res_n      = exec_result_i;
        st_n       = (exec_ctrl_i != ctrl_q) ? ST_TDWB : ST_POST;
      end
      ST_TDWB: if (mem_ack_i) st_n = ST_POST;
      ST_POST: begin
        if (res_q == RES_ABORT) st_n = ST_IDLE;
        else if (inq_q && res_q == RES_ADVANCE) begin elem_n = tdlink_q; st_n = ST_QHWB; end
        else if (inq_q) begin link_n = horiz_q;  st_n = ST_LDEC; end
        else            begin link_n = tdlink_q; st_n = ST_LDEC; end
      end
      ST_QHWB: if (mem_ack_i) begin
        if (elem_q[PTR_DEPTH]) st_n = ST_QDEC;
        else begin link_n = horiz_q; st_n = ST_LDEC; end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; link_q <= '0; horiz_q <= '0; elem_q <= '0;
      tdlink_q <= '0; ctrl_q <= '0; ctrl_new_q <= '0;
      qh_q <= '0; td_q <= '0; res_q <= '0; inq_q <= 1'b0;
    end else begin
      st_q <= st_n; link_q <= link_n; horiz_q <= horiz_n; elem_q <= elem_n;
      tdlink_q <= tdlink_n; ctrl_q <= ctrl_n; ctrl_new_q <= ctrl_new_n;
      qh_q <= qh_n; td_q <= td_n; res_q <= res_n; inq_q <= inq_n;
    end
  end

  always_comb begin
    mem_req_o   = 1'b1;
    mem_we_o    = 1'b0;
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    unique case (st_q)
      ST_ENTRY: mem_addr_o = {list_page_i, frame_num_o[LIST_IDX_W-1:0], 2'b00};
      ST_QH0:   mem_addr_o = qh_q;
      ST_QH1:   mem_addr_o = qh_q + WORD1;
      ST_TD0:   mem_addr_o = td_q;
      ST_TD1:   mem_addr_o = td_q + WORD1;
      ST_TDWB:  begin mem_we_o = 1'b1; mem_addr_o = td_q + WORD1; mem_wdata_o = ctrl_new_q; end
      ST_QHWB:  begin mem_we_o = 1'b1; mem_addr_o = qh_q + WORD1; mem_wdata_o = elem_q; end
      default:  mem_req_o = 1'b0;
    endcase
  end

  assign exec_req_o  = (st_q == ST_EXEC);
  assign exec_addr_o = td_q;
  assign exec_ctrl_o = ctrl_q;
  assign busy_o      = (st_q != ST_IDLE);

  // R12
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));
  // R12
  exec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_req_o && !exec_done_i) |=> (exec_req_o && $stable(exec_addr_o)));
  // R4
  walk_starts_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (mem_req_o && !mem_we_o));
endmodule

// File: tb/sim_frame_walker.sv
module sim_frame_walker;
  localparam int LIMIT = 100;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, tick, run;
  logic [10:0] frame_num;
  logic halted, int_post, busy, mem_req, mem_we, exec_req;
  logic [1:0] int_bits;
  logic [31:0] mem_addr, mem_wdata, exec_addr, exec_ctrl;
  logic        mem_ack = 1'b0, exec_done = 1'b0;
  logic [31:0] mem_rdata = '0, exec_ctrl_new = '0;
  logic [1:0]  exec_result = '0, exec_irq = '0;

  frame_walker #(.MAX_VISITS(LIMIT)) u0 (
    .clk, .rst_n, .frame_tick_i(tick), .run_i(run), .list_page_i(20'h00001),
    .frame_num_o(frame_num), .halted_o(halted), .int_post_o(int_post),
    .int_bits_o(int_bits), .busy_o(busy), .mem_req_o(mem_req), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack),
    .mem_rdata_i(mem_rdata), .exec_req_o(exec_req), .exec_addr_o(exec_addr),
    .exec_ctrl_o(exec_ctrl), .exec_done_i(exec_done), .exec_result_i(exec_result),
    .exec_ctrl_i(exec_ctrl_new), .exec_irq_i(exec_irq));

  // memory and execution models; all writes to mem happen here
  logic [31:0] mem [0:2047];
  logic [31:0] rdlog [0:1023];
  logic [31:0] exlog [0:1023];
  int nrd = 0, nwr = 0, nex = 0;
  logic bw_en = 1'b0;
  logic [31:0] bw_addr = '0, bw_data = '0;

  always @(posedge clk) begin
    if (bw_en) mem[bw_addr[12:2]] <= bw_data;
    if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      if (mem_we) begin
        mem[mem_addr[12:2]] <= mem_wdata;
        nwr <= nwr + 1;
      end else begin
        mem_rdata <= mem[mem_addr[12:2]];
        rdlog[nrd % 1024] <= mem_addr;
        nrd <= nrd + 1;
      end
    end else mem_ack <= 1'b0;
    if (exec_req && !exec_done) begin
      exec_done     <= 1'b1;
      exec_result   <= exec_ctrl[1:0];
      exec_irq      <= exec_ctrl[5:4];
      exec_ctrl_new <= exec_ctrl[8] ? (exec_ctrl | 32'h0100_0000) : exec_ctrl;
      exlog[nex % 1024] <= exec_addr;
      nex <= nex + 1;
    end else exec_done <= 1'b0;
  end

  int nchk = 0, nfail = 0;
  int exp_fn = 0;
  int rd0, wr0, ex0;
  logic post_s;
  logic [1:0] bits_s;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk); bw_en = 1'b1; bw_addr = a; bw_data = d;
    @(negedge clk); bw_en = 1'b0;
  endtask

  task automatic rdm(input logic [31:0] a, output logic [31:0] d);
    d = mem[a[12:2]];
  endtask

  function automatic logic [31:0] entry_addr(input int fn);
    return 32'h1000 | (32'(fn & 1023) << 2);
  endfunction

  task automatic set_entry(input logic [31:0] v);
    wr(entry_addr(exp_fn + 1), v);
  endtask

  task automatic do_frame(input bit mid_tick);
    rd0 = nrd; wr0 = nwr; ex0 = nex;
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    post_s = int_post; bits_s = int_bits;
    if (run) exp_fn = (exp_fn + 1) % 2048;
    repeat (2) @(negedge clk);
    if (mid_tick) begin
      repeat (40) @(negedge clk);
      check(busy == 1'b1, "R13 busy at mid tick", busy, 1);
      tick = 1'b1; @(negedge clk); tick = 1'b0;
    end
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; tick = 1'b0; run = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check(frame_num == 0, "R1 frame", frame_num, 0);
    check(halted == 1'b1, "R1 halted", halted, 1);
    check(!busy && !int_post && !mem_req && !exec_req, "R1 idle outputs",
          {busy, int_post, mem_req, exec_req}, 0);
    for (int i = 0; i < 1024; i++) wr(32'h1000 + 32'(i * 4), 32'h1);

    // R3: stopped tick
    do_frame(1'b0);
    check(halted == 1'b1, "R3 halted", halted, 1);
    check(frame_num == 0, "R3 frame", frame_num, 0);
    check(nrd == rd0, "R3 no access", nrd - rd0, 0);

    // R2, R4: full sweep over all frame numbers
    run = 1'b1;
    for (int f = 1; f <= 2048; f++) begin
      do_frame(1'b0);
      check(frame_num == 11'(exp_fn), "R2 frame number", frame_num, exp_fn);
      check(nrd - rd0 == 1 && rdlog[rd0 % 1024] == entry_addr(exp_fn),
            "R4 entry address", rdlog[rd0 % 1024], entry_addr(exp_fn));
    end
    check(frame_num == 0, "R2 wrap", frame_num, 0);
    check(halted == 1'b0, "R2 halted cleared", halted, 0);

    // R6 R7: horizontal chain, retry then advance
    wr(32'h200, 32'h220); wr(32'h204, 32'h101);
    wr(32'h220, 32'h1);   wr(32'h224, 32'h0);
    set_entry(32'h200);
    do_frame(1'b0);
    check(nex - ex0 == 2 && exlog[ex0 % 1024] == 32'h200 && exlog[(ex0 + 1) % 1024] == 32'h220,
          "R6 horizontal chain", nex - ex0, 2);
    rdm(32'h204, v); check(v == 32'h0100_0101, "R7 changed ctrl written", v, 32'h0100_0101);
    check(nwr - wr0 == 1, "R7 unchanged ctrl not written", nwr - wr0, 1);
    wr(entry_addr(exp_fn), 32'h1);

    // R8: depth-first advance through a queue, irq 01 raised
    wr(32'h100, 32'h1); wr(32'h104, 32'h300);
    wr(32'h300, 32'h324); wr(32'h304, 32'h0);
    wr(32'h320, 32'h1);   wr(32'h324, 32'h10);
    set_entry(32'h102);
    do_frame(1'b0);
    check(nex - ex0 == 2 && exlog[(ex0 + 1) % 1024] == 32'h320, "R8 depth-first order",
          exlog[(ex0 + 1) % 1024], 32'h320);
    rdm(32'h104, v); check(v == 32'h1, "R8 element advanced", v, 1);
    check(nwr - wr0 == 2, "R8 element writes", nwr - wr0, 2);
    wr(entry_addr(exp_fn), 32'h1);

    // R8 R5: breadth-first over two queues; R11 post from previous frame
    wr(32'h140, 32'h182); wr(32'h144, 32'h400);
    wr(32'h400, 32'h420); wr(32'h404, 32'h0);
    wr(32'h180, 32'h1);   wr(32'h184, 32'h440);
    wr(32'h440, 32'h1);   wr(32'h444, 32'h1);
    set_entry(32'h142);
    do_frame(1'b0);
    check(post_s == 1'b1 && bits_s == 2'b01, "R11 post bits", {post_s, bits_s}, 3'b101);
    check(nex - ex0 == 2 && exlog[ex0 % 1024] == 32'h400 && exlog[(ex0 + 1) % 1024] == 32'h440,
          "R8 breadth-first order", exlog[(ex0 + 1) % 1024], 32'h440);
    rdm(32'h144, v); check(v == 32'h420, "R8 breadth element", v, 32'h420);
    rdm(32'h184, v); check(v == 32'h440, "R8 retry keeps element", v, 32'h440);
    wr(entry_addr(exp_fn), 32'h1);

    // R5: nested queue drops outer horizontal link; R11 no post
    wr(32'h1C0, 32'h500); wr(32'h1C4, 32'h1E2);
    wr(32'h1E0, 32'h1);   wr(32'h1E4, 32'h480);
    wr(32'h480, 32'h1);   wr(32'h484, 32'h1);
    wr(32'h500, 32'h1);   wr(32'h504, 32'h0);
    set_entry(32'h1C2);
    do_frame(1'b0);
    check(post_s == 1'b0, "R11 no post without irq", post_s, 0);
    check(nex - ex0 == 1 && exlog[ex0 % 1024] == 32'h480, "R5 nested descend",
          exlog[ex0 % 1024], 32'h480);
    wr(entry_addr(exp_fn), 32'h1);

    // R9: abort stops the walk after write-back
    wr(32'h600, 32'h620); wr(32'h604, 32'h102);
    wr(32'h620, 32'h1);   wr(32'h624, 32'h0);
    set_entry(32'h600);
    do_frame(1'b0);
    check(nex - ex0 == 1, "R9 abort ends walk", nex - ex0, 1);
    rdm(32'h604, v); check(v == 32'h0100_0102, "R9 write-back before abort", v, 32'h0100_0102);
    wr(entry_addr(exp_fn), 32'h1);

    // R10 R13: self-linked queue hits the visit budget; tick mid-walk ignored
    wr(32'h700, 32'h702); wr(32'h704, 32'h1);
    set_entry(32'h702);
    do_frame(1'b1);
    check(nrd - rd0 == 2 * LIMIT + 1, "R10 visit budget reads", nrd - rd0, 2 * LIMIT + 1);
    check(frame_num == 11'(exp_fn), "R13 busy tick ignored", frame_num, exp_fn);
    wr(entry_addr(exp_fn), 32'h1);

    // R3 then R2 again
    run = 1'b0;
    do_frame(1'b0);
    check(halted == 1'b1 && frame_num == 11'(exp_fn), "R3 stop after run", halted, 1);
    run = 1'b1;
    do_frame(1'b0);
    check(halted == 1'b0 && frame_num == 11'(exp_fn), "R2 restart", frame_num, exp_fn);

    report();
  end
endmodule